// File: doc/BRIEF.md
# Burst Word-Program Staging Buffer

This block holds up to four 32-bit words that software stages ahead of a burst flash write, then pushes them to a flash word-program port one at a time. Each stored word carries its own pending bit. A software write to a data register sets that bit. The flash acknowledge for that word clears it. A go strobe carries a start address. On go, the block walks the words from lowest to highest index, and the target address advances by four bytes per word position. It issues a request only for words whose pending bit is set, and it stops after the highest pending word.

Register index 0 is a single-word data view. It shares storage with data word 0, so the single-word and burst paths see the same value. While a burst runs, a status register reports busy, active and pending state, and an address register follows the word in progress. After the burst ends, the address register keeps the last address that was used. The status register also shows a read-only copy of an external fail flag. Data writes and go strobes that arrive while the block is busy are dropped, and a conflict pulse reports each one. Command legality and erase handling sit upstream and are not part of this block.

Top module: `mwp_stage_buf`

## Requirements
- R1: After reset, every data word reads 0, the status register (index 1) reads 0, the address register (index 2) reads 0 and no flash request is raised.
- R2: Register index 0 and register index 4 are the same storage: a value written through either index reads back through both, and it sets pending bit 0.
- R3: While the block is idle, a write to data index 4+i (i = 0..3) stores the value and sets status bit i, the pending bit of word i.
- R4: A go with at least one pending word programs the pending words in order from 0 to 3. Word i goes to start address + 4*i with its stored data. Each request stays asserted, with stable address and data, until the acknowledge. The acknowledge clears that word's pending bit.
- R5: A word without a pending bit gets no request, but its address slot is still counted. The burst ends after the highest pending word.
- R6: Go loads the address register with the start address. During the burst the register shows the address of the word in progress. After the burst it holds the last programmed address.
- R7: Status bit 8 (busy) is 1 from the cycle after an accepted go until one cycle after the last acknowledge. Status bit 9 (active) is 1 while words are being programmed.
- R8: A go with no pending word sets busy for exactly one cycle. Active stays 0, no request is raised, and the address register takes the go address.
- R9: While busy, data-register writes and go strobes are ignored: stored words, pending bits and the burst's addresses are unchanged. The conflict output is 1 for the one cycle after each ignored access.
- R10: Status bit 10 always equals the fail input.
- R11: Writes to the status and address indices have no effect and raise no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_idx |
| go | input | 1 | Burst start strobe |
| go_addr | input | 32 | Burst start byte address |
| fail_in | input | 1 | External fail flag, mirrored into status |
| fl_req | output | 1 | Flash word-program request |
| fl_addr | output | 32 | Flash target byte address |
| fl_data | output | 32 | Flash program data |
| fl_ack | input | 1 | Flash word-program acknowledge |
| conflict | output | 1 | One-cycle pulse for an access dropped while busy |

## Verification
The bench stages sparse patterns in which only words 0 and 2 are pending, or only word 3. A design that dropped the skipped slots from the address count would program the wrong address. A design that stopped at the first gap would lose the later word. A go with nothing pending must produce a one-cycle busy pulse and no request; a design that entered the programming phase here would hang or issue a request for stale data. The bench also writes data and pulses go in the middle of a burst. A design that let these through would corrupt the staged data, re-arm a pending bit or restart the burst at the new address, and each of these shows up at the flash port or in the register reads.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_e;

    localparam int unsigned IDX_SINGLE = 0;
    localparam int unsigned IDX_STATUS = 1;
    localparam int unsigned IDX_ADDR   = 2;

    localparam int unsigned ST_BUSY_BIT = 8;
    localparam int unsigned ST_ACT_BIT  = 9;
    localparam int unsigned ST_FAIL_BIT = 10;

endpackage

// File: rtl/mwp_word_bank.sv
module mwp_word_bank #(
    parameter int NW = 4,
    parameter int DW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NW-1:0]          ld_en,
    input  logic [DW-1:0]          ld_data,
    input  logic [NW-1:0]          clr,
    output logic [NW-1:0][DW-1:0]  words,
    output logic [NW-1:0]          pend
);

    for (genvar g = 0; g < NW; g++) begin : g_word
        typedef struct packed {
            logic [DW-1:0] data;
            logic          pend;
        } slot_t;

        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr[g]) begin
                slot_d.pend = 1'b0;
            end
            if (ld_en[g]) begin
                slot_d.data = ld_data;
                slot_d.pend = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign words[g] = slot_q.data;
        assign pend[g]  = slot_q.pend;

        AST_PEND_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            ld_en[g] |=> pend[g]); // R3
        AST_PEND_OFF_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !ld_en[g]) |=> !pend[g]); // R4
    end

endmodule

// File: rtl/mwp_sequencer.sv
module mwp_sequencer
    import mwp_pkg::*;
#(
    parameter int NW   = 4,
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [AW-1:0]          go_addr,
    input  logic [NW-1:0]          pend,
    input  logic [NW-1:0][DW-1:0]  words,
    input  logic                   fl_ack,
    output logic                   fl_req,
    output logic [AW-1:0]          fl_addr,
    output logic [DW-1:0]          fl_data,
    output logic [NW-1:0]          clr,
    output logic                   busy,
    output logic                   active,
    output logic [AW-1:0]          cur_addr
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    typedef struct packed {
        sq_state_e     st;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
    } sq_t;

    sq_t  sq_d, sq_q;
    logic more_hi;

    always_comb begin
        more_hi = 1'b0;
        for (int i = 0; i < NW; i++) begin
            if (i > int'(sq_q.idx)) begin
                more_hi = more_hi | pend[i];
            end
        end
    end

    always_comb begin
        sq_d   = sq_q;
        fl_req = 1'b0;
        clr    = '0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (go) begin
                    sq_d.addr = go_addr;
                    sq_d.idx  = '0;
                    sq_d.st   = (|pend) ? SQ_RUN : SQ_FIN;
                end
            end
            SQ_RUN: begin
                if (pend[sq_q.idx]) begin
                    fl_req = 1'b1;
                    if (fl_ack) begin
                        clr[sq_q.idx] = 1'b1;
                        if (more_hi) begin
                            sq_d.idx  = sq_q.idx + 1'b1;
                            sq_d.addr = sq_q.addr + AW'(STEP);
                        end else begin
                            sq_d.st = SQ_FIN;
                        end
                    end
                end else if (more_hi) begin
                    sq_d.idx  = sq_q.idx + 1'b1;
                    sq_d.addr = sq_q.addr + AW'(STEP);
                end else begin
                    sq_d.st = SQ_FIN;
                end
            end
            SQ_FIN: begin
                sq_d.st = SQ_IDLE;
            end
            default: begin
                sq_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, idx: '0, addr: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign fl_addr  = sq_q.addr;
    assign fl_data  = words[sq_q.idx];
    assign busy     = (sq_q.st != SQ_IDLE);
    assign active   = (sq_q.st == SQ_RUN);
    assign cur_addr = sq_q.addr;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_data))); // R4
    AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> active); // R7
    AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == SQ_FIN) |=> (sq_q.st == SQ_IDLE)); // R8
    AST_ADDR_KEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(cur_addr)); // R6
    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R4

endmodule

// File: rtl/mwp_regif.sv
module mwp_regif
    import mwp_pkg::*;
#(
    parameter int NW  = 4,
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int RAW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [RAW-1:0]         reg_idx,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   go,
    input  logic                   busy,
    input  logic                   active,
    input  logic [NW-1:0]          pend,
    input  logic [NW-1:0][DW-1:0]  words,
    input  logic [AW-1:0]          cur_addr,
    input  logic                   fail_in,
    output logic [NW-1:0]          ld_en,
    output logic                   go_ok,
    output logic                   conflict
);

    typedef struct packed {
        logic conflict;
    } rif_t;

    rif_t rif_d, rif_q;
    logic is_data;
    logic [NW-1:0] sel;
    logic [DW-1:0] status_w;

    always_comb begin
        sel     = '0;
        is_data = 1'b0;
        if (int'(reg_idx) == int'(IDX_SINGLE)) begin
            is_data = 1'b1;
            sel[0]  = 1'b1;
        end
        for (int i = 0; i < NW; i++) begin
            if (int'(reg_idx) == NW + i) begin
                is_data = 1'b1;
                sel[i]  = 1'b1;
            end
        end
    end

    always_comb begin
        ld_en = (reg_wr && is_data && !busy) ? sel : '0;
        go_ok = go && !busy;
        rif_d = rif_q;
        rif_d.conflict = busy && ((reg_wr && is_data) || go);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rif_q <= '0;
        end else begin
            rif_q <= rif_d;
        end
    end

    assign conflict = rif_q.conflict;

    always_comb begin
        status_w = '0;
        status_w[NW-1:0]    = pend;
        status_w[ST_BUSY_BIT] = busy;
        status_w[ST_ACT_BIT]  = active;
        status_w[ST_FAIL_BIT] = fail_in;
    end

    always_comb begin
        reg_rdata = '0;
        if (is_data) begin
            for (int i = 0; i < NW; i++) begin
                if (sel[i]) begin
                    reg_rdata = words[i];
                end
            end
        end else if (int'(reg_idx) == int'(IDX_STATUS)) begin
            reg_rdata = status_w;
        end else if (int'(reg_idx) == int'(IDX_ADDR)) begin
            reg_rdata = DW'(cur_addr);
        end
    end

    AST_CONFLICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> conflict); // R9
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !conflict); // R11

endmodule

// File: rtl/mwp_stage_buf.sv
module mwp_stage_buf #(
    parameter int NW  = 4,
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int RAW = $clog2(2 * NW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_idx,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            go,
    input  logic [AW-1:0]   go_addr,
    input  logic            fail_in,
    output logic            fl_req,
    output logic [AW-1:0]   fl_addr,
    output logic [DW-1:0]   fl_data,
    input  logic            fl_ack,
    output logic            conflict
);

    localparam int STEP = DW / 8;

    logic [NW-1:0]          ld_en;
    logic [NW-1:0]          clr;
    logic [NW-1:0]          pend;
    logic [NW-1:0][DW-1:0]  words;
    logic                   go_ok;
    logic                   busy;
    logic                   active;
    logic [AW-1:0]          cur_addr;

    mwp_word_bank #(.NW(NW), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_data (reg_wdata),
        .clr     (clr),
        .words   (words),
        .pend    (pend)
    );

    mwp_sequencer #(.NW(NW), .DW(DW), .AW(AW), .STEP(STEP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_ok),
        .go_addr  (go_addr),
        .pend     (pend),
        .words    (words),
        .fl_ack   (fl_ack),
        .fl_req   (fl_req),
        .fl_addr  (fl_addr),
        .fl_data  (fl_data),
        .clr      (clr),
        .busy     (busy),
        .active   (active),
        .cur_addr (cur_addr)
    );

    mwp_regif #(.NW(NW), .DW(DW), .AW(AW), .RAW(RAW)) u_rif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .go        (go),
        .busy      (busy),
        .active    (active),
        .pend      (pend),
        .words     (words),
        .cur_addr  (cur_addr),
        .fail_in   (fail_in),
        .ld_en     (ld_en),
        .go_ok     (go_ok),
        .conflict  (conflict)
    );

    AST_WORDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(words)); // R9
    AST_NO_REARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pend[0]) |=> !pend[0]); // R9

endmodule

// File: tb/sim_mwp_stage_buf.sv
module sim_mwp_stage_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        go = 1'b0;
    logic [31:0] go_addr = '0;
    logic        fail_in = 1'b0;
    logic        fl_req;
    logic [31:0] fl_addr;
    logic [31:0] fl_data;
    logic        fl_ack = 1'b0;
    logic        conflict;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    int log_n   = 0;
    logic [31:0] log_a [0:15];
    logic [31:0] log_d [0:15];
    logic [31:0] st_go;
    logic        conf_go;
    logic        conf_wr;

    always #4 clk = ~clk;

    mwp_stage_buf u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .go        (go),
        .go_addr   (go_addr),
        .fail_in   (fail_in),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .fl_data   (fl_data),
        .fl_ack    (fl_ack),
        .conflict  (conflict)
    );

    // flash responder: acknowledges each request after lat cycles and logs it
    initial begin
        forever begin
            @(negedge clk);
            if (fl_req && !fl_ack) begin
                repeat (lat) @(negedge clk);
                if (log_n < 16) begin
                    log_a[log_n] = fl_addr;
                    log_d[log_n] = fl_data;
                end
                log_n++;
                fl_ack = 1'b1;
                @(negedge clk);
                fl_ack = 1'b0;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_idx = 3'(idx);
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        conf_wr = conflict;
    endtask

    task automatic rd(int idx, output logic [31:0] val);
        @(negedge clk);
        reg_idx = 3'(idx);
        #1;
        val = reg_rdata;
    endtask

    task automatic start(logic [31:0] a);
        @(negedge clk);
        go = 1'b1;
        go_addr = a;
        reg_idx = 3'd1;
        @(negedge clk);
        go = 1'b0;
        #1;
        st_go = reg_rdata;
        conf_go = conflict;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 300; k++) begin
            rd(1, s);
            if (!s[8]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1, v); check("R1 status", v, 32'h0);
        rd(2, v); check("R1 address", v, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(4 + i, v); check("R1 word", v, 32'h0);
        end
        check("R1 no request", 32'(fl_req), 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(0, 32'hA5A5_0001);
        check("R11 no conflict idle", 32'(conf_wr), 32'h0);
        rd(4, v); check("R2 index0 to index4", v, 32'hA5A5_0001);
        wr(4, 32'h1234_5678);
        rd(0, v); check("R2 index4 to index0", v, 32'h1234_5678);
        rd(1, v); check("R2 pending bit0", v, 32'h1);
    endtask

    task automatic t_full_burst();
        logic [31:0] v;
        wr(5, 32'h1111_0001);
        wr(6, 32'h2222_0002);
        wr(7, 32'h3333_0003);
        rd(1, v); check("R3 pending all", v, 32'hF);
        lat = 6; log_n = 0;
        start(32'h0000_1000);
        check("R7 busy active after go", st_go, 32'h0000_030F);
        rd(2, v); check("R6 address at first word", v, 32'h0000_1000);
        wr(5, 32'hDEAD_BEEF);
        check("R9 conflict on write", 32'(conf_wr), 32'h1);
        start(32'h0000_9000);
        check("R9 conflict on go", 32'(conf_go), 32'h1);
        wait_idle();
        check("R4 request count", 32'(log_n), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R4 address order", log_a[i], 32'h1000 + 32'(4 * i));
        end
        check("R4 data w0", log_d[0], 32'h1234_5678);
        check("R4 data w1", log_d[1], 32'h1111_0001);
        check("R4 data w3", log_d[3], 32'h3333_0003);
        rd(1, v); check("R4 pending cleared, busy low", v, 32'h0);
        rd(2, v); check("R6 final address", v, 32'h0000_100C);
        rd(5, v); check("R9 word kept", v, 32'h1111_0001);
    endtask

    task automatic t_gap();
        logic [31:0] v;
        wr(0, 32'hCAFE_0000);
        wr(6, 32'hCAFE_0002);
        lat = 0; log_n = 0;
        start(32'h0000_2000);
        wait_idle();
        check("R5 gap request count", 32'(log_n), 32'd2);
        check("R5 gap first address", log_a[0], 32'h0000_2000);
        check("R5 gap second address", log_a[1], 32'h0000_2008);
        check("R5 gap second data", log_d[1], 32'hCAFE_0002);
        rd(2, v); check("R6 gap final address", v, 32'h0000_2008);
    endtask

    task automatic t_last_only();
        logic [31:0] v;
        wr(7, 32'hBEEF_0003);
        lat = 1; log_n = 0;
        start(32'h0000_4000);
        wait_idle();
        check("R5 last-only count", 32'(log_n), 32'd1);
        check("R5 last-only address", log_a[0], 32'h0000_400C);
        rd(2, v); check("R6 last-only final", v, 32'h0000_400C);
    endtask

    task automatic t_empty_go();
        logic [31:0] v;
        log_n = 0;
        start(32'h0000_3000);
        check("R8 busy one cycle, no active", st_go, 32'h0000_0100);
        rd(1, v); check("R8 busy gone", v, 32'h0);
        repeat (4) @(negedge clk);
        check("R8 no request", 32'(log_n), 32'd0);
        rd(2, v); check("R8 address loaded", v, 32'h0000_3000);
    endtask

    task automatic t_fail_mirror();
        logic [31:0] v;
        fail_in = 1'b1;
        rd(1, v); check("R10 fail set", v, 32'h0000_0400);
        fail_in = 1'b0;
        rd(1, v); check("R10 fail clear", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(1, 32'hFFFF_FFFF);
        check("R11 status write no conflict", 32'(conf_wr), 32'h0);
        rd(1, v); check("R11 status unchanged", v, 32'h0);
        wr(2, 32'h0BAD_0000);
        rd(2, v); check("R11 address unchanged", v, 32'h0000_3000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alias();
        t_full_burst();
        t_gap();
        t_last_only();
        t_empty_go();
        t_fail_mirror();
        t_readonly();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule